// File: doc/BRIEF.md
# Programmable Edge-Delay Phase Generator

This block derives three internal sampling phases for a correlated-double-sampling front end from three timing strobes: a black-level strobe, a pixel (video-level) strobe and a converter clock. Everything runs on one fast oversampling clock, and one clock tick counts as one delay step. Each strobe first has its polarity corrected. On the corrected signal the falling edge counts as the leading edge and the rising edge as the trailing edge. Each edge is then shifted late by its own 3-bit delay field, 0 to 7 ticks.

Two 9-bit delay words each hold three fields. Word A sets the black phase's falling and rising delays and the converter-phase delay. Word B sets the video phase's falling and rising delays and a chained extra delay. A direct-mode bit picks where the video phase's falling edge comes from. In chained mode (0) it starts at the black phase's delayed rising edge, adds the chained delay, then adds the video falling delay. In direct mode (1) it follows the pixel strobe's leading edge.

Configuration and polarity changes are held back until no delayed edge is pending, so a phase is never built from a mix of old and new settings.

Top module: `phase_gen`

## Requirements
- R1: During synchronous reset, each phase output loads the polarity-corrected level of its source strobe (the video phase uses the pixel strobe). After reset no edge is issued until a source strobe changes.
- R2: The corrected strobe equals the raw strobe XOR its invert bit (`blk_inv`, `pix_inv`). The converter clock is never inverted. Leading edge means a falling corrected edge and trailing edge means a rising corrected edge.
- R3: `ph_black` falls A[2:0] ticks after a black leading edge.
- R4: `ph_black` rises A[5:3] ticks after a black trailing edge.
- R5: `ph_video` rises B[5:3] ticks after a pixel trailing edge, in both modes.
- R6: With `pix_direct`=1, `ph_video` falls B[2:0] ticks after a pixel leading edge. B[8:6] and the black edges then have no effect on `ph_video`.
- R7: With `pix_direct`=0, `ph_video` falls B[8:6]+B[2:0] ticks after `ph_black` rises. Pixel leading edges then have no effect.
- R8: `ph_conv` follows the converter clock delayed by A[8:6] ticks on both edges.
- R9: Latency is counted from E0, the first rising clock edge that samples a new strobe level. An edge with delay d appears at the output at edge E0+d. A delay of 0 therefore appears at E0 itself, on every path.
- R10: If an edge is detected while an earlier delayed edge of the same phase is still pending, the pending edge is issued at that clock edge. The new edge is then delayed by its field value, with a minimum of 1 tick.
- R11: New delay words, invert bits and the mode bit are captured only at a clock edge where no delayed edge is pending and no strobe edge is detected. A change made while an edge is pending does not alter that edge's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock, one tick per delay step |
| rst | input | 1 | Synchronous active-high reset |
| blk_strobe | input | 1 | Raw black-level strobe |
| pix_strobe | input | 1 | Raw pixel (video-level) strobe |
| cnv_clk | input | 1 | Raw converter clock |
| dly_a | input | 9 | [2:0] black fall, [5:3] black rise, [8:6] converter delay |
| dly_b | input | 9 | [2:0] video fall, [5:3] video rise, [8:6] chained delay |
| blk_inv | input | 1 | Invert black strobe before edge detection |
| pix_inv | input | 1 | Invert pixel strobe before edge detection |
| pix_direct | input | 1 | 1: video fall from pixel leading edge; 0: chained from black rise |
| ph_black | output | 1 | Black-sample phase |
| ph_video | output | 1 | Video-sample phase |
| ph_conv | output | 1 | Converter phase |

## Verification
All strobe inputs change just after a falling clock edge. The next rising edge is E0, so an edge with delay d is first visible at the falling edge that follows E0+d. Each vector checks the output after exactly d falling edges, where it must still hold its old level, and again after d+1, where it must hold the new level. A chained video edge is checked the same way, with the black rise delay, the chained delay and the video fall delay added into one latency. The collision and deferred-configuration tests sample at the boundary edges worked out from R10 and R11.

// File: rtl/phgen_pkg.sv
package phgen_pkg;
  // source indices for the three strobes
  localparam int unsigned SRC_BLK = 0;
  localparam int unsigned SRC_PIX = 1;
  localparam int unsigned SRC_CNV = 2;
  localparam int unsigned NUM_SRC = 3;
  // fields per delay word
  localparam int unsigned NUM_FIELDS = 3;
endpackage

// File: rtl/phg_cfg_hold.sv
module phg_cfg_hold #(
  parameter int unsigned REG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic [REG_W-1:0] dly_a_in,
  input  logic [REG_W-1:0] dly_b_in,
  input  logic             blk_inv_in,
  input  logic             pix_inv_in,
  input  logic             direct_in,
  output logic [REG_W-1:0] dly_a_q,
  output logic [REG_W-1:0] dly_b_q,
  output logic             blk_inv_q,
  output logic             pix_inv_q,
  output logic             direct_q
);
  // capture happens in reset and whenever no edge is in flight
  always_ff @(posedge clk) begin
    if (rst || idle) begin
      dly_a_q   <= dly_a_in;
      dly_b_q   <= dly_b_in;
      blk_inv_q <= blk_inv_in;
      pix_inv_q <= pix_inv_in;
      direct_q  <= direct_in;
    end
  end
endmodule

// File: rtl/phg_pulse_delay.sv
module phg_pulse_delay #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_pulse,
  input  logic [CNT_W-1:0] dly,
  output logic             out_pulse,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dly_min1;

  always_comb begin
    dly_min1  = (dly == '0) ? ONE : dly;
    pend_d    = pend_q;
    cnt_d     = cnt_q;
    out_pulse = 1'b0;
    if (in_pulse) begin
      if (pend_q) begin
        // flush the older pulse first, then queue the new one
        out_pulse = 1'b1;
        pend_d    = 1'b1;
        cnt_d     = dly_min1;
      end else if (dly == '0) begin
        out_pulse = 1'b1;
      end else begin
        pend_d = 1'b1;
        cnt_d  = dly;
      end
    end else if (pend_q) begin
      if (cnt_q == ONE) begin
        out_pulse = 1'b1;
        pend_d    = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = pend_q;
endmodule

// File: rtl/phg_edge_shaper.sv
module phg_edge_shaper #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_lvl,
  input  logic             lead_evt,
  input  logic             trail_evt,
  input  logic [CNT_W-1:0] lead_dly,
  input  logic [CNT_W-1:0] trail_dly,
  output logic             phase,
  output logic             busy,
  output logic             rise_now
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             pend_q, pend_d;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_d;
  logic [CNT_W-1:0] sel_dly, sel_min1;

  // lead and trail alternate, so one counter covers both edges
  always_comb begin
    sel_dly  = trail_evt ? trail_dly : lead_dly;
    sel_min1 = (sel_dly == '0) ? ONE : sel_dly;
    phase_d  = phase;
    pend_d   = pend_q;
    lvl_d    = lvl_q;
    cnt_d    = cnt_q;
    if (lead_evt && trail_evt) begin
      phase_d = 1'b0;
      pend_d  = 1'b1;
      lvl_d   = 1'b1;
      cnt_d   = sel_min1;
    end else if (lead_evt || trail_evt) begin
      lvl_d = trail_evt;
      if (pend_q) begin
        phase_d = lvl_q;
        pend_d  = 1'b1;
        cnt_d   = sel_min1;
      end else if (sel_dly == '0) begin
        phase_d = trail_evt;
        pend_d  = 1'b0;
      end else begin
        pend_d = 1'b1;
        cnt_d  = sel_dly;
      end
    end else if (pend_q) begin
      if (cnt_q == ONE) begin
        phase_d = lvl_q;
        pend_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= init_lvl;
      pend_q <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      phase  <= phase_d;
      pend_q <= pend_d;
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy     = pend_q;
  assign rise_now = phase_d & ~phase;
endmodule

// File: rtl/phase_gen.sv
module phase_gen
  import phgen_pkg::*;
#(
  parameter int unsigned STEP_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       blk_strobe,
  input  logic                       pix_strobe,
  input  logic                       cnv_clk,
  input  logic [NUM_FIELDS*STEP_W-1:0] dly_a,
  input  logic [NUM_FIELDS*STEP_W-1:0] dly_b,
  input  logic                       blk_inv,
  input  logic                       pix_inv,
  input  logic                       pix_direct,
  output logic                       ph_black,
  output logic                       ph_video,
  output logic                       ph_conv
);
  localparam int unsigned REG_W = NUM_FIELDS * STEP_W;

  logic [REG_W-1:0]   dly_a_q, dly_b_q;
  logic               blk_inv_q, pix_inv_q, direct_q;
  logic               cfg_idle;

  logic [NUM_SRC-1:0] raw, inv_in, inv_q, corr, prev_q, rise_p, fall_p;
  logic [NUM_SRC-1:0] init_lvl, lead_evt, trail_evt, phase, busy, rise_now;
  logic [STEP_W-1:0]  lead_dly  [NUM_SRC];
  logic [STEP_W-1:0]  trail_dly [NUM_SRC];
  logic [STEP_W-1:0]  fa [NUM_FIELDS];
  logic [STEP_W-1:0]  fb [NUM_FIELDS];

  logic               chain_in, chain_out, chain_busy;

  phg_cfg_hold #(.REG_W(REG_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .idle       (cfg_idle),
    .dly_a_in   (dly_a),
    .dly_b_in   (dly_b),
    .blk_inv_in (blk_inv),
    .pix_inv_in (pix_inv),
    .direct_in  (pix_direct),
    .dly_a_q    (dly_a_q),
    .dly_b_q    (dly_b_q),
    .blk_inv_q  (blk_inv_q),
    .pix_inv_q  (pix_inv_q),
    .direct_q   (direct_q)
  );

  // field split of the held delay words
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign fa[f] = dly_a_q[f*STEP_W +: STEP_W];
    assign fb[f] = dly_b_q[f*STEP_W +: STEP_W];
  end

  // polarity correction and edge detection
  always_comb begin
    raw              = '0;
    raw[SRC_BLK]     = blk_strobe;
    raw[SRC_PIX]     = pix_strobe;
    raw[SRC_CNV]     = cnv_clk;
    inv_in           = '0;
    inv_in[SRC_BLK]  = blk_inv;
    inv_in[SRC_PIX]  = pix_inv;
    inv_q            = '0;
    inv_q[SRC_BLK]   = blk_inv_q;
    inv_q[SRC_PIX]   = pix_inv_q;
    corr             = raw ^ inv_q;
    rise_p           = corr & ~prev_q;
    fall_p           = ~corr & prev_q;
    init_lvl         = raw ^ inv_in;
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_idle) prev_q <= raw ^ inv_in;
    else                 prev_q <= corr;
  end

  // chained path from the black rise to the video fall
  assign chain_in = ~direct_q & rise_now[SRC_BLK];

  phg_pulse_delay #(.CNT_W(STEP_W)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .in_pulse  (chain_in),
    .dly       (fb[2]),
    .out_pulse (chain_out),
    .busy      (chain_busy)
  );

  // edge routing per phase
  always_comb begin
    lead_evt[SRC_BLK]  = fall_p[SRC_BLK];
    trail_evt[SRC_BLK] = rise_p[SRC_BLK];
    lead_dly[SRC_BLK]  = fa[0];
    trail_dly[SRC_BLK] = fa[1];

    lead_evt[SRC_PIX]  = direct_q ? fall_p[SRC_PIX] : chain_out;
    trail_evt[SRC_PIX] = rise_p[SRC_PIX];
    lead_dly[SRC_PIX]  = fb[0];
    trail_dly[SRC_PIX] = fb[1];

    lead_evt[SRC_CNV]  = fall_p[SRC_CNV];
    trail_evt[SRC_CNV] = rise_p[SRC_CNV];
    lead_dly[SRC_CNV]  = fa[2];
    trail_dly[SRC_CNV] = fa[2];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_shape
    phg_edge_shaper #(.CNT_W(STEP_W)) u_shape (
      .clk       (clk),
      .rst       (rst),
      .init_lvl  (init_lvl[s]),
      .lead_evt  (lead_evt[s]),
      .trail_evt (trail_evt[s]),
      .lead_dly  (lead_dly[s]),
      .trail_dly (trail_dly[s]),
      .phase     (phase[s]),
      .busy      (busy[s]),
      .rise_now  (rise_now[s])
    );
  end

  assign cfg_idle = ~(|busy) & ~chain_busy & ~(|rise_p) & ~(|fall_p);

  assign ph_black = phase[SRC_BLK];
  assign ph_video = phase[SRC_PIX];
  assign ph_conv  = phase[SRC_CNV];
endmodule

// File: rtl/phg_checker.sv
module phg_checker #(
  parameter int unsigned CW = 21
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cfg_all,
  input logic [2:0]    busy,
  input logic          chain_busy,
  input logic          direct_q,
  input logic [2:0]    rise_p,
  input logic [2:0]    fall_p,
  input logic          a0_zero,
  input logic          ph_black,
  input logic          ph_conv
);
  logic any_busy;
  assign any_busy = (|busy) | chain_busy;

  AST_CFG_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    any_busy |=> $stable(cfg_all)); // R11

  AST_BLK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy[0] && !rise_p[0] && !fall_p[0]) |=> $stable(ph_black)); // R3

  AST_CNV_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy[2] && !rise_p[2] && !fall_p[2]) |=> $stable(ph_conv)); // R8

  AST_BLK_ZERO_FALL: assert property (@(posedge clk) disable iff (rst)
    (fall_p[0] && !busy[0] && a0_zero) |=> !ph_black); // R9

  AST_DIRECT_NO_CHAIN: assert property (@(posedge clk) disable iff (rst)
    direct_q |-> !chain_busy); // R6

  AST_COLLIDE_REQUEUE: assert property (@(posedge clk) disable iff (rst)
    (busy[0] && (rise_p[0] || fall_p[0])) |=> busy[0]); // R10
endmodule

bind phase_gen phg_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_all    ({dly_a_q, dly_b_q, blk_inv_q, pix_inv_q, direct_q}),
  .busy       (busy),
  .chain_busy (chain_busy),
  .direct_q   (direct_q),
  .rise_p     (rise_p),
  .fall_p     (fall_p),
  .a0_zero    (fa[0] == '0),
  .ph_black   (ph_black),
  .ph_conv    (ph_conv)
);

// File: tb/sim_phase_gen.sv
module sim_phase_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_strobe = 1'b1, pix_strobe = 1'b1, cnv_clk = 1'b0;
  logic [8:0] dly_a = '0, dly_b = '0;
  logic blk_inv = 1'b0, pix_inv = 1'b0, pix_direct = 1'b1;
  logic ph_black, ph_video, ph_conv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phase_gen u0 (
    .clk(clk), .rst(rst), .blk_strobe(blk_strobe), .pix_strobe(pix_strobe),
    .cnv_clk(cnv_clk), .dly_a(dly_a), .dly_b(dly_b), .blk_inv(blk_inv),
    .pix_inv(pix_inv), .pix_direct(pix_direct),
    .ph_black(ph_black), .ph_video(ph_video), .ph_conv(ph_conv)
  );

  // vector: a(9) b(9) direct(1) src(2) lvl(1) out(2) exp(1) lat(5) pre(1)
  localparam int VW = 31;
  localparam int NV = 20;
  localparam logic [VW-1:0] VEC [NV] = '{
    {9'o003, 9'o000, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 5'd3, 1'b1}, // R3
    {9'o050, 9'o000, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 5'd5, 1'b1}, // R4
    {9'o000, 9'o004, 1'b1, 2'd1, 1'b0, 2'd1, 1'b0, 5'd4, 1'b1}, // R6
    {9'o000, 9'o020, 1'b1, 2'd1, 1'b1, 2'd1, 1'b1, 5'd2, 1'b1}, // R5
    {9'o600, 9'o000, 1'b1, 2'd2, 1'b1, 2'd2, 1'b1, 5'd6, 1'b1}, // R8
    {9'o600, 9'o000, 1'b1, 2'd2, 1'b0, 2'd2, 1'b0, 5'd6, 1'b1}, // R8
    {9'o000, 9'o000, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 5'd0, 1'b1}, // R9
    {9'o000, 9'o000, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 5'd0, 1'b1}, // R9
    {9'o000, 9'o000, 1'b1, 2'd1, 1'b0, 2'd1, 1'b0, 5'd0, 1'b1}, // R9
    {9'o000, 9'o000, 1'b1, 2'd1, 1'b1, 2'd1, 1'b1, 5'd0, 1'b1}, // R9
    {9'o000, 9'o000, 1'b1, 2'd2, 1'b1, 2'd2, 1'b1, 5'd0, 1'b1}, // R9
    {9'o000, 9'o000, 1'b1, 2'd2, 1'b0, 2'd2, 1'b0, 5'd0, 1'b1}, // R9
    {9'o000, 9'o000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd0, 1'b1}, // R3
    {9'o020, 9'o301, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 5'd6, 1'b1}, // R7 chained
    {9'o000, 9'o000, 1'b0, 2'd1, 1'b0, 2'd1, 1'b0, 5'd3, 1'b0}, // R7 pix lead ignored
    {9'o000, 9'o010, 1'b0, 2'd1, 1'b1, 2'd1, 1'b1, 5'd1, 1'b1}, // R5
    {9'o000, 9'o000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd0, 1'b1}, // R9
    {9'o000, 9'o000, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 5'd0, 1'b1}, // R7 R9
    {9'o000, 9'o000, 1'b0, 2'd1, 1'b0, 2'd1, 1'b0, 5'd2, 1'b0}, // R7
    {9'o000, 9'o000, 1'b0, 2'd1, 1'b1, 2'd1, 1'b1, 5'd0, 1'b1}  // R5
  };

  function automatic logic out_of(input logic [1:0] idx);
    case (idx)
      2'd0:    out_of = ph_black;
      2'd1:    out_of = ph_video;
      default: out_of = ph_conv;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] src, input logic lvl);
    case (src)
      2'd0:    blk_strobe = lvl;
      2'd1:    pix_strobe = lvl;
      default: cnv_clk    = lvl;
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    // reset state R1
    nwait(3);
    rst = 1'b0;
    nwait(2);
    chk("R1 black", ph_black, 1'b1);
    chk("R1 video", ph_video, 1'b1);
    chk("R1 conv",  ph_conv,  1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      int lat;
      v = VEC[i];
      dly_a = v[30:22];
      dly_b = v[21:13];
      pix_direct = v[12];
      lat = int'(v[5:1]);
      nwait(2);
      drive(v[11:10], v[9]);
      if (lat > 0) nwait(lat);
      if (v[0]) chk($sformatf("vec%0d before", i), out_of(v[8:7]), ~v[6]);
      nwait(1);
      chk($sformatf("vec%0d after", i), out_of(v[8:7]), v[6]);
      nwait(12);
    end

    // R10 collision: pending fall flushed at the rise's detect edge
    dly_a = 9'o055; dly_b = '0; pix_direct = 1'b1;
    nwait(2);
    blk_strobe = 1'b0;
    nwait(1);
    blk_strobe = 1'b1;
    nwait(1);
    chk("R10 flushed fall", ph_black, 1'b0);
    nwait(4);
    chk("R10 rise not yet", ph_black, 1'b0);
    nwait(1);
    chk("R10 rise", ph_black, 1'b1);
    nwait(12);

    // R11 deferred configuration
    dly_a = 9'o002;
    nwait(2);
    blk_strobe = 1'b0;
    nwait(1);
    dly_a = 9'o007;
    nwait(1);
    chk("R11 old delay holds", ph_black, 1'b1);
    nwait(1);
    chk("R11 old delay fall", ph_black, 1'b0);
    nwait(3);
    blk_strobe = 1'b1;
    nwait(1);
    chk("R11 new rise delay", ph_black, 1'b1);
    nwait(3);
    blk_strobe = 1'b0;
    nwait(7);
    chk("R11 new fall pending", ph_black, 1'b1);
    nwait(1);
    chk("R11 new fall", ph_black, 1'b0);
    nwait(3);
    blk_strobe = 1'b1;
    nwait(12);

    // R6 chained field and black edges ignored in direct mode
    dly_a = '0; dly_b = 9'o700; pix_direct = 1'b1;
    nwait(2);
    blk_strobe = 1'b0;
    nwait(3);
    blk_strobe = 1'b1;
    nwait(12);
    chk("R6 video untouched", ph_video, 1'b1);

    // R2 polarity: inverted strobes after reset
    rst = 1'b1;
    blk_inv = 1'b1; pix_inv = 1'b1;
    blk_strobe = 1'b0; pix_strobe = 1'b0;
    dly_a = 9'o003; dly_b = 9'o002; pix_direct = 1'b1;
    nwait(3);
    rst = 1'b0;
    nwait(2);
    chk("R2 R1 black", ph_black, 1'b1);
    chk("R2 R1 video", ph_video, 1'b1);
    blk_strobe = 1'b1;
    nwait(3);
    chk("R2 black before", ph_black, 1'b1);
    nwait(1);
    chk("R2 black inverted fall", ph_black, 1'b0);
    nwait(4);
    pix_strobe = 1'b1;
    nwait(2);
    chk("R2 video before", ph_video, 1'b1);
    nwait(1);
    chk("R2 video inverted fall", ph_video, 1'b0);
    nwait(4);

    finish_run();
  end
endmodule